// File: doc/BRIEF.md
# Transmit Completion Status Stack

This block keeps one status byte for every frame the transmitter has finished, until host software collects it. The transmit engine offers a record on a push port together with four flag bits. The block turns those flags into a stored byte, adding a "record valid" bit and, when records have been lost, an overflow bit. The host sees the oldest pending record on its read bus. Any write strobe from the host removes that record.

A one-cycle completion event tells the interrupt controller that a pushed frame asked for attention. The event fires when the frame requested an interrupt or carries an error flag. Jabber and underrun are fatal. Either one latches a need-reset output that stays high until the transmitter reset input is pulsed. That reset also flushes every pending record.

Occupancy is tracked by a three-state machine with these states:
- `ST_EMPTY`: nothing stored.
- `ST_PART`: between one and DEPTH-1 records stored.
- `ST_FULL`: DEPTH records stored.

It has these transitions:
- EMPTY→PART on an accepted push, or EMPTY→FULL when DEPTH is 1.
- PART→FULL on a push without a pop while DEPTH-1 records are held.
- PART→EMPTY on a pop without a push while one record is held.
- FULL→PART on a pop without a push, or FULL→EMPTY when DEPTH is 1.
- FULL→FULL on a push with or without a pop.
- Any state→EMPTY on the transmitter reset.

Top module: `txc_status_stack`

## Requirements
- R1: A stored record reads as {bit7=1, bit6=interrupt requested, bit5=jabber, bit4=underrun, bit3=maximum collisions, bit2=overflow, bits1..0=0}. The push flag vector is ordered [3]=interrupt requested, [2]=jabber, [1]=underrun, [0]=maximum collisions.
- R2: With no record pending, the read bus returns 0x00, including right after reset.
- R3: Records leave in the order in which they were pushed, and the read bus always shows the oldest one.
- R4: A host write strobe pops the oldest record. A write strobe while the stack is empty changes nothing.
- R5: A push while DEPTH (default 4) records are held and no pop occurs is dropped. Bit 2 of the most recently stored record is set, and all other stored bits are unchanged.
- R6: A push and a pop in the same cycle on a full stack both take effect, and no overflow is marked.
- R7: The completion event is high for exactly the cycle after a push whose flag vector is nonzero. This holds whether or not the record is stored. The event is low after every other cycle.
- R8: Need-reset goes high the cycle after a push with jabber or underrun set, and it stays high until the transmitter reset.
- R9: The transmitter reset empties the stack and clears need-reset. A push or pop in the same cycle is discarded, and no event is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| push_i | input | 1 | Transmitter offers a completion record |
| push_flags_i | input | 4 | {intr_req, jabber, underrun, max_coll} |
| host_wr_i | input | 1 | Host write strobe to the status register (pops) |
| tx_reset_i | input | 1 | Transmitter reset: flush and clear need-reset |
| host_rd_data_o | output | 8 | Oldest pending record, 0 when empty |
| txc_event_o | output | 1 | One-cycle completion event |
| need_reset_o | output | 1 | Fatal error latched, transmitter reset needed |

## Verification
The bench builds the block with the default DEPTH of 4. At that depth the full boundary is reached after only four pushes, so dropped pushes, repeated overflow marking on the same newest record, and a push with a pop at the full boundary can all be driven in a short run. Four entries also leave enough room for the pointers to wrap several times. This exposes an ordering fault that only appears once the write pointer has passed the read pointer's starting slot.

// File: rtl/txc_pkg.sv
package txc_pkg;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_PART  = 2'd1,
        ST_FULL  = 2'd2
    } stk_state_t;

    localparam int FLAG_W = 4;
    localparam int REC_W  = 8;
    localparam int OVF_BIT = 2;

    function automatic logic [REC_W-1:0] make_rec(input logic [FLAG_W-1:0] flags);
        return {1'b1, flags, 1'b0, 2'b00};
    endfunction

endpackage

// File: rtl/txc_ctrl.sv
module txc_ctrl
    import txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic push_i,
    input  logic pop_i,
    input  logic flush_i,
    output logic wr_en_o,
    output logic rd_en_o,
    output logic ovf_mark_o,
    output logic empty_o
);
    localparam int CW = $clog2(DEPTH + 1);

    stk_state_t state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic pop_ok, room;

    always_comb begin
        pop_ok     = pop_i && (state_q != ST_EMPTY);
        room       = (state_q != ST_FULL) || pop_ok;
        wr_en_o    = push_i && room && !flush_i;
        rd_en_o    = pop_ok && !flush_i;
        ovf_mark_o = push_i && !room && !flush_i;
        empty_o    = (state_q == ST_EMPTY);
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q + CW'(wr_en_o) - CW'(rd_en_o);
        unique case (state_q)
            ST_EMPTY: if (wr_en_o) state_d = (DEPTH == 1) ? ST_FULL : ST_PART;
            ST_PART: begin
                if (wr_en_o && !rd_en_o && cnt_q == CW'(DEPTH - 1)) state_d = ST_FULL;
                else if (rd_en_o && !wr_en_o && cnt_q == CW'(1))    state_d = ST_EMPTY;
            end
            ST_FULL: if (rd_en_o && !wr_en_o) state_d = (DEPTH == 1) ? ST_EMPTY : ST_PART;
            default: state_d = ST_EMPTY;
        endcase
        if (flush_i) begin
            state_d = ST_EMPTY;
            cnt_d   = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EMPTY && pop_i && !push_i && !flush_i) |=> state_q == ST_EMPTY);

    assert_full_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && push_i && !pop_i && !flush_i) |=> (state_q == ST_FULL && $stable(cnt_q)));

    assert_full_swap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FULL && push_i && pop_i && !flush_i) |-> (wr_en_o && !ovf_mark_o));

    assert_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (state_q == ST_EMPTY && cnt_q == '0));

endmodule

// File: rtl/txc_store.sv
module txc_store
    import txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              ovf_mark_i,
    input  logic              flush_i,
    input  logic              empty_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic [REC_W-1:0]  rd_data_o
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [REC_W-1:0] mem_q [DEPTH];
    logic [PW-1:0]    wr_ptr_q, rd_ptr_q, last_idx;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    assign last_idx  = (wr_ptr_q == '0) ? PW'(DEPTH - 1) : wr_ptr_q - PW'(1);
    assign rd_data_o = empty_i ? '0 : mem_q[rd_ptr_q];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
        end else begin
            if (wr_en_i) begin
                mem_q[wr_ptr_q] <= make_rec(flags_i);
                wr_ptr_q        <= bump(wr_ptr_q);
            end
            if (ovf_mark_i) mem_q[last_idx][OVF_BIT] <= 1'b1;
            if (rd_en_i)    rd_ptr_q <= bump(rd_ptr_q);
        end
    end

    assert_first_in_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && empty_i && !flush_i) |=> rd_data_o[6:3] == $past(flags_i));

    assert_ovf_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_mark_i |=> mem_q[$past(last_idx)][OVF_BIT]);

endmodule

// File: rtl/txc_flags.sv
module txc_flags
    import txc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              flush_i,
    input  logic [FLAG_W-1:0] flags_i,
    output logic              event_o,
    output logic              need_reset_o
);
    logic fatal;
    assign fatal = flags_i[2] || flags_i[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            event_o      <= 1'b0;
            need_reset_o <= 1'b0;
        end else begin
            event_o <= push_i && !flush_i && (flags_i != '0);
            if (flush_i)             need_reset_o <= 1'b0;
            else if (push_i && fatal) need_reset_o <= 1'b1;
        end
    end

    assert_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !flush_i && flags_i != '0) |=> event_o);

    assert_no_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i || flush_i) |=> !event_o);

    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (need_reset_o && !flush_i) |=> need_reset_o);

endmodule

// File: rtl/txc_status_stack.sv
module txc_status_stack
    import txc_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [FLAG_W-1:0] push_flags_i,
    input  logic              host_wr_i,
    input  logic              tx_reset_i,
    output logic [REC_W-1:0]  host_rd_data_o,
    output logic              txc_event_o,
    output logic              need_reset_o
);
    logic wr_en, rd_en, ovf_mark, empty;

    txc_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(host_wr_i),
        .flush_i(tx_reset_i), .wr_en_o(wr_en), .rd_en_o(rd_en),
        .ovf_mark_o(ovf_mark), .empty_o(empty)
    );

    txc_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
        .ovf_mark_i(ovf_mark), .flush_i(tx_reset_i), .empty_i(empty),
        .flags_i(push_flags_i), .rd_data_o(host_rd_data_o)
    );

    txc_flags u_flags (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .flush_i(tx_reset_i),
        .flags_i(push_flags_i), .event_o(txc_event_o), .need_reset_o(need_reset_o)
    );

    assert_rec_shape_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !empty |-> (host_rd_data_o[7] && host_rd_data_o[1:0] == 2'b00));

    assert_reset_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_reset_i |=> (host_rd_data_o == '0 && !need_reset_o));

    assert_empty_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_reset_i && !push_i) |=> $countones(host_rd_data_o) == 0);

endmodule

// File: tb/sim_txc_status_stack.sv
`timescale 1ns/1ps
module sim_txc_status_stack;
    localparam int DEPTH = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push = 1'b0;
    logic [3:0] flags = 4'h0;
    logic       hwr = 1'b0;
    logic       txr = 1'b0;
    logic [7:0] rd;
    logic       ev, nr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] q[$];
    logic       exp_ev = 1'b0;
    logic       exp_nr = 1'b0;

    always #2.5 clk = ~clk;

    txc_status_stack #(.DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push), .push_flags_i(flags),
        .host_wr_i(hwr), .tx_reset_i(txr), .host_rd_data_o(rd),
        .txc_event_o(ev), .need_reset_o(nr)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: compares the visible head against the scoreboard queue front.
    task automatic monitor(input string tag);
        chk(tag, rd, (q.size() > 0) ? q[0] : 8'h00);
        chk("R7 event", {7'd0, ev}, {7'd0, exp_ev});
        chk("R8 need_reset", {7'd0, nr}, {7'd0, exp_nr});
    endtask

    // Driver: applies one operation and updates the scoreboard.
    task automatic drive(input logic p, input logic [3:0] f, input logic w,
                         input logic r, input string tag);
        int old;
        bit popok;
        @(negedge clk);
        push = p; flags = f; hwr = w; txr = r;
        if (r) begin
            q.delete();
            exp_nr = 1'b0;
            exp_ev = 1'b0;
        end else begin
            old   = q.size();
            popok = w && (old > 0);
            if (popok) void'(q.pop_front());
            if (p) begin
                if (old < DEPTH || popok) q.push_back({1'b1, f, 3'b000});
                else q[q.size()-1][2] = 1'b1;
                if (f[2] || f[1]) exp_nr = 1'b1;
            end
            exp_ev = p && (f != 4'h0);
        end
        @(negedge clk);
        push = 1'b0; flags = 4'h0; hwr = 1'b0; txr = 1'b0;
        monitor(tag);
        exp_ev = 1'b0;
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=hung expected=finished");
        if (!done) begin
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset read", rd, 8'h00);
        chk("R7 reset event", {7'd0, ev}, 8'h00);
        chk("R8 reset need", {7'd0, nr}, 8'h00);
        rst_n = 1'b1;

        // R1 / R3: format and order
        drive(1, 4'b1000, 0, 0, "R1 intr only");
        drive(1, 4'b0001, 0, 0, "R1 maxcoll");
        drive(1, 4'b0000, 0, 0, "R7 quiet push");
        drive(0, 4'h0, 1, 0, "R3 pop 1");
        drive(0, 4'h0, 1, 0, "R3 pop 2");
        drive(0, 4'h0, 1, 0, "R4 pop last");
        drive(0, 4'h0, 1, 0, "R4 pop empty");
        chk("R2 empty read", rd, 8'h00);

        // R5: fill and overflow, pointers wrap
        drive(1, 4'b0001, 0, 0, "R5 fill a");
        drive(1, 4'b1000, 0, 0, "R5 fill b");
        drive(1, 4'b0000, 0, 0, "R5 fill c");
        drive(1, 4'b1001, 0, 0, "R5 fill d");
        drive(1, 4'b0001, 0, 0, "R5 drop 1");
        drive(1, 4'b0000, 0, 0, "R5 drop 2");

        // R6: full with push and pop
        drive(1, 4'b1000, 1, 0, "R6 swap");
        drive(0, 4'h0, 1, 0, "R3 drain 1");
        drive(0, 4'h0, 1, 0, "R3 drain 2");
        drive(0, 4'h0, 1, 0, "R5 newest ovf");
        drive(0, 4'h0, 1, 0, "R6 last");
        drive(0, 4'h0, 1, 0, "R2 drained");

        // R8 / R9: fatal flags and reset
        drive(1, 4'b0010, 0, 0, "R8 underrun");
        drive(1, 4'b0000, 0, 0, "R8 held");
        drive(1, 4'b0100, 0, 0, "R8 jabber");
        drive(0, 4'h0, 1, 0, "R8 after pop");
        drive(0, 4'h0, 0, 1, "R9 flush");
        drive(1, 4'b0110, 0, 1, "R9 push discarded");
        drive(1, 4'b1100, 0, 0, "R1 after reset");
        drive(0, 4'h0, 1, 0, "R4 final pop");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule